// File: doc/BRIEF.md
# Finished Segment Detector Table

This block keeps one record per local label for a single vertical image slice. Each record holds a bounding box, a valid bit and a two-bit row stamp. The labelling logic drives one update port. It sends pixel updates, which create or grow a box, and merge requests, which fold one label's box into another's. Each image row ends with a one-cycle strobe.

Every strobe starts a sweep on a second, independent read port. The sweep walks the labels in ascending order, one per cycle, during the row that follows. A record that is valid and was last written two rows back (modulo four) received no pixel during the row that just ended, so its segment is complete. The sweep presents the box on the report outputs, clears the record and queues the label in a recycle FIFO. The label allocator drains that FIFO with a ready handshake.

Top module: `seg_finish_table`

## Requirements
- R1: After reset no report is presented, the recycle FIFO is empty and every record is invalid.
- R2: A pixel update (upd_merge = 0) to an invalid record makes it valid with a box of exactly that pixel (x min = x max = upd_x, y min = y max = upd_y).
- R3: A pixel update to a valid record widens its box to include the pixel; every reported box has min not above max on both axes.
- R4: Every write stamps the record with the current row number modulo 4. A record written during a row is not reported by the sweep in the next row.
- R5: The sweep starts at label 0 after each row strobe and examines labels in ascending order, one per cycle. It reports a record that is valid and whose stamp equals the current row number minus 2 (modulo 4).
- R6: A reported record is invalidated; a later pixel update to that label starts a fresh single-pixel box.
- R7: Each reported label is pushed to the recycle FIFO in report order. The FIFO head (rec_label with rec_valid = 1) is held until rec_ready is high.
- R8: A merge (upd_merge = 1) gives record upd_label the union of its own box and that of upd_src, valid if either was valid, and stamps it. Record upd_src is invalidated and never reported.
- R9: If the update port writes the record the sweep examines in the same cycle, the write wins and that record is not reported in that sweep.
- R10: Label L is examined L+1 cycles after the clock edge that samples row_end and appears on the report outputs after that edge. A new row strobe may only come once the sweep has reached its last label.
- R11: The recycle FIFO holds DEPTH labels and is never pushed when full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_end | input | 1 | One-cycle strobe at the last cycle of a row |
| upd_valid | input | 1 | Update request present |
| upd_merge | input | 1 | 0 = pixel update, 1 = merge |
| upd_label | input | LBL_W | Record written |
| upd_src | input | LBL_W | Record folded in and invalidated by a merge |
| upd_x | input | XW | Pixel column |
| upd_y | input | YW | Pixel row |
| rec_ready | input | 1 | Allocator accepts the FIFO head |
| fin_valid | output | 1 | Finished segment reported this cycle |
| fin_label | output | LBL_W | Label of the finished segment |
| fin_xmin | output | XW | Box left edge |
| fin_xmax | output | XW | Box right edge |
| fin_ymin | output | YW | Box top edge |
| fin_ymax | output | YW | Box bottom edge |
| rec_valid | output | 1 | Recycle FIFO not empty |
| rec_label | output | LBL_W | Label at the FIFO head |

## Verification
The bench builds the table with eight records and 8-bit coordinates. With that size a full sweep fits in an eleven-cycle row, so the bench can run many rows in a short time. The same size also puts the label wrap from 7 to 0 and a FIFO holding several labels within reach. A behavioural model tracks records, row stamps, the sweep position and the FIFO contents, and is compared with the outputs on every clock. Directed rows place a merge, a sweep collision on a stale record, label reuse after recycling and a stalled FIFO consumer at chosen cycles.

// File: rtl/seg_fin_pkg.sv
package seg_fin_pkg;
   localparam int TAG_W = 2;

   typedef enum logic {
      UPD_PIXEL = 1'b0,
      UPD_MERGE = 1'b1
   } upd_kind_e;

   function automatic logic [TAG_W-1:0] stale_stamp(input logic [TAG_W-1:0] row);
      return row - TAG_W'(2);
   endfunction
endpackage

// File: rtl/seg_fin_store.sv
module seg_fin_store
   import seg_fin_pkg::*;
#(
   parameter int DEPTH = 32,
   parameter int LBL_W = 5,
   parameter int XW    = 12,
   parameter int YW    = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             a_en,
   input  upd_kind_e        a_kind,
   input  logic [LBL_W-1:0] a_lbl,
   input  logic [LBL_W-1:0] a_src,
   input  logic [XW-1:0]    a_x,
   input  logic [YW-1:0]    a_y,
   input  logic [TAG_W-1:0] a_stamp,
   input  logic [LBL_W-1:0] b_idx,
   input  logic             b_clr,
   output logic             b_valid,
   output logic [TAG_W-1:0] b_stamp,
   output logic [XW-1:0]    b_xmin,
   output logic [XW-1:0]    b_xmax,
   output logic [YW-1:0]    b_ymin,
   output logic [YW-1:0]    b_ymax,
   output logic             b_touch
);
   logic             v_arr  [DEPTH];
   logic [TAG_W-1:0] t_arr  [DEPTH];
   logic [XW-1:0]    xl_arr [DEPTH];
   logic [XW-1:0]    xh_arr [DEPTH];
   logic [YW-1:0]    yl_arr [DEPTH];
   logic [YW-1:0]    yh_arr [DEPTH];

   // merge source, read through the update port
   logic          s_valid;
   logic [XW-1:0] s_xl, s_xh;
   logic [YW-1:0] s_yl, s_yh;
   assign s_valid = v_arr[a_src];
   assign s_xl    = xl_arr[a_src];
   assign s_xh    = xh_arr[a_src];
   assign s_yl    = yl_arr[a_src];
   assign s_yh    = yh_arr[a_src];

   // sweep read port
   assign b_valid = v_arr[b_idx];
   assign b_stamp = t_arr[b_idx];
   assign b_xmin  = xl_arr[b_idx];
   assign b_xmax  = xh_arr[b_idx];
   assign b_ymin  = yl_arr[b_idx];
   assign b_ymax  = yh_arr[b_idx];
   assign b_touch = a_en && ((a_lbl == b_idx) ||
                             ((a_kind == UPD_MERGE) && (a_src == b_idx)));

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic             v_q;
      logic [TAG_W-1:0] t_q;
      logic [XW-1:0]    xl_q, xh_q, xl_n, xh_n;
      logic [YW-1:0]    yl_q, yh_q, yl_n, yh_n;
      logic             v_n, hit_d, hit_s;

      assign hit_d = a_en && (a_lbl == LBL_W'(i));
      assign hit_s = a_en && (a_kind == UPD_MERGE) &&
                     (a_src == LBL_W'(i)) && (a_src != a_lbl);

      always_comb begin
         v_n  = v_q;
         xl_n = xl_q;
         xh_n = xh_q;
         yl_n = yl_q;
         yh_n = yh_q;
         if (a_kind == UPD_PIXEL) begin
            v_n = 1'b1;
            if (v_q) begin
               xl_n = (a_x < xl_q) ? a_x : xl_q;
               xh_n = (a_x > xh_q) ? a_x : xh_q;
               yl_n = (a_y < yl_q) ? a_y : yl_q;
               yh_n = (a_y > yh_q) ? a_y : yh_q;
            end else begin
               xl_n = a_x;
               xh_n = a_x;
               yl_n = a_y;
               yh_n = a_y;
            end
         end else begin
            v_n = v_q | s_valid;
            if (v_q && s_valid) begin
               xl_n = (s_xl < xl_q) ? s_xl : xl_q;
               xh_n = (s_xh > xh_q) ? s_xh : xh_q;
               yl_n = (s_yl < yl_q) ? s_yl : yl_q;
               yh_n = (s_yh > yh_q) ? s_yh : yh_q;
            end else if (s_valid) begin
               xl_n = s_xl;
               xh_n = s_xh;
               yl_n = s_yl;
               yh_n = s_yh;
            end
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v_q  <= 1'b0;
            t_q  <= '0;
            xl_q <= '0;
            xh_q <= '0;
            yl_q <= '0;
            yh_q <= '0;
         end else if (hit_d) begin
            v_q  <= v_n;
            t_q  <= a_stamp;
            xl_q <= xl_n;
            xh_q <= xh_n;
            yl_q <= yl_n;
            yh_q <= yh_n;
         end else if (hit_s) begin
            v_q <= 1'b0;
         end else if (b_clr && (b_idx == LBL_W'(i))) begin
            v_q <= 1'b0;
         end
      end

      assign v_arr[i]  = v_q;
      assign t_arr[i]  = t_q;
      assign xl_arr[i] = xl_q;
      assign xh_arr[i] = xh_q;
      assign yl_arr[i] = yl_q;
      assign yh_arr[i] = yh_q;
   end
endmodule

// File: rtl/seg_fin_scan.sv
module seg_fin_scan
   import seg_fin_pkg::*;
#(
   parameter int DEPTH = 32,
   parameter int LBL_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             row_end,
   input  logic [TAG_W-1:0] row_stamp,
   input  logic             rd_valid,
   input  logic [TAG_W-1:0] rd_stamp,
   input  logic             touch,
   output logic [LBL_W-1:0] idx,
   output logic             busy,
   output logic             last,
   output logic             found
);
   logic [LBL_W-1:0] idx_q;
   logic             busy_q;

   assign idx   = idx_q;
   assign busy  = busy_q;
   assign last  = (idx_q == LBL_W'(DEPTH - 1));
   assign found = busy_q && rd_valid && !touch &&
                  (rd_stamp == stale_stamp(row_stamp));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q  <= '0;
         busy_q <= 1'b0;
      end else if (row_end) begin
         idx_q  <= '0;
         busy_q <= 1'b1;
      end else if (busy_q) begin
         if (last) busy_q <= 1'b0;
         else      idx_q  <= idx_q + LBL_W'(1);
      end
   end
endmodule

// File: rtl/seg_fin_fifo.sv
module seg_fin_fifo #(
   parameter int DEPTH = 32,
   parameter int W     = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop_req,
   output logic         head_valid,
   output logic [W-1:0] head_data,
   output logic         full
);
   localparam int PW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wr_q, rd_q;
   logic [CW-1:0] cnt_q;
   logic          pop;

   assign head_valid = (cnt_q != '0);
   assign head_data  = mem[rd_q];
   assign full       = (cnt_q == CW'(DEPTH));
   assign pop        = pop_req && head_valid;

   always_ff @(posedge clk) begin
      if (push) mem[wr_q] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) wr_q <= wr_q + PW'(1);
         if (pop)  rd_q <= rd_q + PW'(1);
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + CW'(1);
            2'b01:   cnt_q <= cnt_q - CW'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end
endmodule

// File: rtl/seg_finish_table.sv
module seg_finish_table
   import seg_fin_pkg::*;
#(
   parameter int DEPTH = 32,
   parameter int XW    = 12,
   parameter int YW    = 11,
   parameter int LBL_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             row_end,
   input  logic             upd_valid,
   input  logic             upd_merge,
   input  logic [LBL_W-1:0] upd_label,
   input  logic [LBL_W-1:0] upd_src,
   input  logic [XW-1:0]    upd_x,
   input  logic [YW-1:0]    upd_y,
   input  logic             rec_ready,
   output logic             fin_valid,
   output logic [LBL_W-1:0] fin_label,
   output logic [XW-1:0]    fin_xmin,
   output logic [XW-1:0]    fin_xmax,
   output logic [YW-1:0]    fin_ymin,
   output logic [YW-1:0]    fin_ymax,
   output logic             rec_valid,
   output logic [LBL_W-1:0] rec_label
);
   if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
      initial $fatal(1, "seg_finish_table: DEPTH must be a power of two >= 2");
   end
   if (LBL_W != $clog2(DEPTH)) begin : g_bad_lbl
      initial $fatal(1, "seg_finish_table: LBL_W must equal clog2(DEPTH)");
   end
   if ((XW < 1) || (YW < 1)) begin : g_bad_coord
      initial $fatal(1, "seg_finish_table: coordinate widths must be positive");
   end

   logic [TAG_W-1:0] row_stamp_q;
   logic [LBL_W-1:0] scan_idx;
   logic             scan_busy, scan_last, scan_found;
   logic             rd_valid, rd_touch;
   logic [TAG_W-1:0] rd_stamp;
   logic [XW-1:0]    rd_xmin, rd_xmax;
   logic [YW-1:0]    rd_ymin, rd_ymax;
   logic             fifo_full;
   upd_kind_e        kind;

   assign kind = upd_merge ? UPD_MERGE : UPD_PIXEL;

   always_ff @(posedge clk) begin
      if (!rst_n)       row_stamp_q <= '0;
      else if (row_end) row_stamp_q <= row_stamp_q + TAG_W'(1);
   end

   seg_fin_store #(.DEPTH(DEPTH), .LBL_W(LBL_W), .XW(XW), .YW(YW)) store_i (
      .clk(clk), .rst_n(rst_n),
      .a_en(upd_valid), .a_kind(kind), .a_lbl(upd_label), .a_src(upd_src),
      .a_x(upd_x), .a_y(upd_y), .a_stamp(row_stamp_q),
      .b_idx(scan_idx), .b_clr(scan_found),
      .b_valid(rd_valid), .b_stamp(rd_stamp),
      .b_xmin(rd_xmin), .b_xmax(rd_xmax), .b_ymin(rd_ymin), .b_ymax(rd_ymax),
      .b_touch(rd_touch)
   );

   seg_fin_scan #(.DEPTH(DEPTH), .LBL_W(LBL_W)) scan_i (
      .clk(clk), .rst_n(rst_n), .row_end(row_end), .row_stamp(row_stamp_q),
      .rd_valid(rd_valid), .rd_stamp(rd_stamp), .touch(rd_touch),
      .idx(scan_idx), .busy(scan_busy), .last(scan_last), .found(scan_found)
   );

   seg_fin_fifo #(.DEPTH(DEPTH), .W(LBL_W)) fifo_i (
      .clk(clk), .rst_n(rst_n),
      .push(scan_found), .push_data(scan_idx), .pop_req(rec_ready),
      .head_valid(rec_valid), .head_data(rec_label), .full(fifo_full)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fin_valid <= 1'b0;
         fin_label <= '0;
         fin_xmin  <= '0;
         fin_xmax  <= '0;
         fin_ymin  <= '0;
         fin_ymax  <= '0;
      end else begin
         fin_valid <= scan_found;
         if (scan_found) begin
            fin_label <= scan_idx;
            fin_xmin  <= rd_xmin;
            fin_xmax  <= rd_xmax;
            fin_ymin  <= rd_ymin;
            fin_ymax  <= rd_ymax;
         end
      end
   end
endmodule

// File: rtl/seg_finish_table_chk.sv
module seg_finish_table_chk #(
   parameter int LBL_W = 5,
   parameter int XW    = 12,
   parameter int YW    = 11
) (
   input logic             clk,
   input logic             rst_n,
   input logic             row_end,
   input logic             upd_valid,
   input logic             upd_merge,
   input logic [LBL_W-1:0] upd_label,
   input logic             fin_valid,
   input logic [LBL_W-1:0] fin_label,
   input logic [XW-1:0]    fin_xmin,
   input logic [XW-1:0]    fin_xmax,
   input logic [YW-1:0]    fin_ymin,
   input logic [YW-1:0]    fin_ymax,
   input logic             rec_valid,
   input logic             rec_ready,
   input logic [LBL_W-1:0] rec_label,
   input logic             scan_busy,
   input logic             scan_last,
   input logic             fifo_push,
   input logic             fifo_full
);
   assert_box_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fin_valid |-> (fin_xmin <= fin_xmax) && (fin_ymin <= fin_ymax));

   assert_ascending_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fin_valid && $past(fin_valid) |-> fin_label == $past(fin_label) + LBL_W'(1));

   assert_head_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid && !rec_ready |=> rec_valid && $stable(rec_label));

   assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fin_valid |-> !($past(upd_valid) && !$past(upd_merge) && $past(upd_label) == fin_label));

   assert_row_long_R10: assert property (@(posedge clk) disable iff (!rst_n)
      row_end && scan_busy |-> scan_last);

   assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_push && fifo_full |-> rec_ready);
endmodule

bind seg_finish_table seg_finish_table_chk #(.LBL_W(LBL_W), .XW(XW), .YW(YW)) chk_i (
   .clk(clk), .rst_n(rst_n), .row_end(row_end),
   .upd_valid(upd_valid), .upd_merge(upd_merge), .upd_label(upd_label),
   .fin_valid(fin_valid), .fin_label(fin_label),
   .fin_xmin(fin_xmin), .fin_xmax(fin_xmax), .fin_ymin(fin_ymin), .fin_ymax(fin_ymax),
   .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_label(rec_label),
   .scan_busy(scan_busy), .scan_last(scan_last),
   .fifo_push(scan_found), .fifo_full(fifo_full)
);

// File: tb/seg_finish_table_tb.sv
module seg_finish_table_tb_top;
   localparam int DEPTH = 8;
   localparam int LBL_W = 3;
   localparam int XW    = 8;
   localparam int YW    = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             row_end = 1'b0;
   logic             upd_valid = 1'b0;
   logic             upd_merge = 1'b0;
   logic [LBL_W-1:0] upd_label = '0;
   logic [LBL_W-1:0] upd_src = '0;
   logic [XW-1:0]    upd_x = '0;
   logic [YW-1:0]    upd_y = '0;
   logic             rec_ready = 1'b0;
   logic             fin_valid;
   logic [LBL_W-1:0] fin_label;
   logic [XW-1:0]    fin_xmin, fin_xmax;
   logic [YW-1:0]    fin_ymin, fin_ymax;
   logic             rec_valid;
   logic [LBL_W-1:0] rec_label;

   int tests = 0;
   int fails = 0;

   always #10 clk = ~clk;

   seg_finish_table #(.DEPTH(DEPTH), .XW(XW), .YW(YW)) dut_i (
      .clk(clk), .rst_n(rst_n), .row_end(row_end),
      .upd_valid(upd_valid), .upd_merge(upd_merge), .upd_label(upd_label),
      .upd_src(upd_src), .upd_x(upd_x), .upd_y(upd_y), .rec_ready(rec_ready),
      .fin_valid(fin_valid), .fin_label(fin_label),
      .fin_xmin(fin_xmin), .fin_xmax(fin_xmax), .fin_ymin(fin_ymin), .fin_ymax(fin_ymax),
      .rec_valid(rec_valid), .rec_label(rec_label)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int  m_valid [DEPTH];
   int  m_stamp [DEPTH];
   int  m_xl [DEPTH];
   int  m_xh [DEPTH];
   int  m_yl [DEPTH];
   int  m_yh [DEPTH];
   int  m_row, m_idx;
   bit  m_busy;
   bit  e_fin;
   int  e_lbl, e_xl, e_xh, e_yl, e_yh;
   int  rq[$];
   int  cyc = 0;
   int  re_cyc = 0;

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            m_valid[i] = 0; m_stamp[i] = 0;
            m_xl[i] = 0; m_xh[i] = 0; m_yl[i] = 0; m_yh[i] = 0;
         end
         m_row = 0; m_idx = 0; m_busy = 0; e_fin = 0;
         rq.delete();
      end else begin
         bit touch, found;
         int d, s;
         d = int'(upd_label);
         s = int'(upd_src);
         touch = upd_valid && (d == m_idx || (upd_merge && s == m_idx));
         found = m_busy && m_valid[m_idx] != 0 && !touch &&
                 m_stamp[m_idx] == (m_row + 2) % 4;
         e_fin = found;
         if (found) begin
            e_lbl = m_idx;
            e_xl = m_xl[m_idx]; e_xh = m_xh[m_idx];
            e_yl = m_yl[m_idx]; e_yh = m_yh[m_idx];
         end
         if (rec_ready && rq.size() > 0) void'(rq.pop_front());
         if (found) begin
            rq.push_back(m_idx);
            m_valid[m_idx] = 0;
         end
         if (upd_valid) begin
            if (!upd_merge) begin
               if (m_valid[d] != 0) begin
                  if (int'(upd_x) < m_xl[d]) m_xl[d] = int'(upd_x);
                  if (int'(upd_x) > m_xh[d]) m_xh[d] = int'(upd_x);
                  if (int'(upd_y) < m_yl[d]) m_yl[d] = int'(upd_y);
                  if (int'(upd_y) > m_yh[d]) m_yh[d] = int'(upd_y);
               end else begin
                  m_xl[d] = int'(upd_x); m_xh[d] = int'(upd_x);
                  m_yl[d] = int'(upd_y); m_yh[d] = int'(upd_y);
               end
               m_valid[d] = 1;
            end else if (s != d) begin
               if (m_valid[s] != 0) begin
                  if (m_valid[d] != 0) begin
                     if (m_xl[s] < m_xl[d]) m_xl[d] = m_xl[s];
                     if (m_xh[s] > m_xh[d]) m_xh[d] = m_xh[s];
                     if (m_yl[s] < m_yl[d]) m_yl[d] = m_yl[s];
                     if (m_yh[s] > m_yh[d]) m_yh[d] = m_yh[s];
                  end else begin
                     m_xl[d] = m_xl[s]; m_xh[d] = m_xh[s];
                     m_yl[d] = m_yl[s]; m_yh[d] = m_yh[s];
                  end
                  m_valid[d] = 1;
               end
               m_valid[s] = 0;
            end
            m_stamp[d] = m_row;
         end
         if (m_busy) begin
            if (m_idx == DEPTH - 1) m_busy = 0;
            else m_idx++;
         end
         if (row_end) begin
            m_busy = 1; m_idx = 0; m_row = (m_row + 1) % 4;
            re_cyc = cyc;
         end
      end
   end

   // ---------------- per-clock comparison and recording ----------------
   int fin_seq[$];
   int rec_seq[$];
   int fin_cnt [DEPTH];
   int lb_xl [DEPTH];
   int lb_xh [DEPTH];
   int lb_yl [DEPTH];
   int lb_yh [DEPTH];
   int first2_xl = -1, first2_xh = -1;
   int lat1 = -1;
   bit compare_on = 0;

   initial for (int i = 0; i < DEPTH; i++) fin_cnt[i] = 0;

   always @(negedge clk) begin
      if (compare_on) begin
         check(fin_valid == e_fin, "R5 report strobe", int'(fin_valid), int'(e_fin));
         if (e_fin && fin_valid) begin
            check(int'(fin_label) == e_lbl, "R5 report label", int'(fin_label), e_lbl);
            check(int'(fin_xmin) == e_xl && int'(fin_xmax) == e_xh &&
                  int'(fin_ymin) == e_yl && int'(fin_ymax) == e_yh,
                  "R3 report box (xmin)", int'(fin_xmin), e_xl);
         end
         check(rec_valid == (rq.size() > 0), "R7 recycle valid",
               int'(rec_valid), int'(rq.size() > 0));
         if (rq.size() > 0 && rec_valid)
            check(int'(rec_label) == rq[0], "R7 recycle head", int'(rec_label), rq[0]);
         if (fin_valid) begin
            int l;
            l = int'(fin_label);
            fin_seq.push_back(l);
            fin_cnt[l]++;
            lb_xl[l] = int'(fin_xmin); lb_xh[l] = int'(fin_xmax);
            lb_yl[l] = int'(fin_ymin); lb_yh[l] = int'(fin_ymax);
            if (l == 2 && first2_xl < 0) begin
               first2_xl = int'(fin_xmin); first2_xh = int'(fin_xmax);
            end
            if (l == 1) lat1 = cyc - re_cyc;
         end
         if (rec_valid && rec_ready) rec_seq.push_back(int'(rec_label));
      end
   end

   // ---------------- stimulus ----------------
   int rowpos = 0;

   task automatic idle();
      upd_valid = 1'b0;
      @(negedge clk);
      rowpos++;
   endtask

   task automatic pix(input int l, input int x, input int y);
      upd_valid = 1'b1; upd_merge = 1'b0;
      upd_label = LBL_W'(l); upd_x = XW'(x); upd_y = YW'(y);
      @(negedge clk);
      upd_valid = 1'b0;
      rowpos++;
   endtask

   task automatic mrg(input int d, input int s);
      upd_valid = 1'b1; upd_merge = 1'b1;
      upd_label = LBL_W'(d); upd_src = LBL_W'(s);
      @(negedge clk);
      upd_valid = 1'b0; upd_merge = 1'b0;
      rowpos++;
   endtask

   task automatic endrow();
      while (rowpos < 10) idle();
      row_end = 1'b1;
      @(negedge clk);
      row_end = 1'b0;
      rowpos = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      compare_on = 1'b1;
      // R1: reset state at the ports
      check(fin_valid == 1'b0, "R1 no report after reset", int'(fin_valid), 0);
      check(rec_valid == 1'b0, "R1 recycle empty after reset", int'(rec_valid), 0);

      // row 0
      pix(1, 10, 0); pix(2, 20, 0); pix(2, 23, 0); pix(5, 40, 0); endrow();
      // row 1: label 2 left untouched
      pix(1, 11, 1); pix(5, 41, 1); pix(6, 60, 1); pix(7, 70, 1); endrow();
      // row 2: sweep reports 2; label 7 folded into 6
      pix(1, 9, 2); pix(6, 61, 2); mrg(6, 7); endrow();
      // row 3: sweep reports 5
      pix(3, 30, 3); endrow();
      // row 4: label 6 written exactly when the sweep examines it
      pix(3, 31, 4); idle(); idle(); idle(); idle(); idle(); pix(6, 62, 4);
      // R11: recycled labels retained while consumer stalls
      check(rec_valid == 1'b1, "R11 FIFO retains labels", int'(rec_valid), 1);
      check(int'(rec_label) == 2, "R11 FIFO head kept", int'(rec_label), 2);
      endrow();
      // row 5: consumer drains; label 2 reused
      rec_ready = 1'b1;
      pix(2, 50, 5); endrow();
      endrow();  // row 6
      endrow();  // row 7
      endrow();  // row 8
      repeat (12) @(negedge clk);

      // directed checks on the recorded report stream
      begin
         int exp_seq[6] = '{2, 5, 1, 3, 6, 2};
         check(fin_seq.size() == 6, "R5 report count", fin_seq.size(), 6);
         check(rec_seq.size() == 6, "R7 recycle count", rec_seq.size(), 6);
         for (int i = 0; i < 6; i++) begin
            if (i < fin_seq.size())
               check(fin_seq[i] == exp_seq[i], "R5 report order", fin_seq[i], exp_seq[i]);
            if (i < rec_seq.size())
               check(rec_seq[i] == exp_seq[i], "R7 recycle order", rec_seq[i], exp_seq[i]);
         end
      end
      check(first2_xl == 20 && first2_xh == 23, "R3 box widened", first2_xh, 23);
      check(lb_xl[2] == 50 && lb_xh[2] == 50 && lb_yl[2] == 5 && lb_yh[2] == 5,
            "R2 R6 fresh point box after reuse", lb_xl[2], 50);
      check(fin_cnt[1] == 1 && fin_seq.size() > 2 && fin_seq[2] == 1,
            "R4 live label held back", fin_cnt[1], 1);
      check(lb_xl[1] == 9 && lb_xh[1] == 11 && lb_yh[1] == 2, "R3 label 1 box", lb_xl[1], 9);
      check(fin_cnt[7] == 0, "R8 merged source never reported", fin_cnt[7], 0);
      check(lb_xl[6] == 60 && lb_xh[6] == 70 && lb_yl[6] == 1 && lb_yh[6] == 4,
            "R8 merged union box (xmax)", lb_xh[6], 70);
      check(fin_cnt[6] == 1 && fin_seq.size() > 4 && fin_seq[4] == 6,
            "R9 collided record deferred", fin_cnt[6], 1);
      check(lat1 == 2, "R10 report latency of label 1", lat1, 2);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(20 * 4000);
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule